// File: doc/BRIEF.md
# Configurable Track Crossing Switch

This block is the routing crossing that sits between logic tiles. Tracks arrive from four sides (left, right, top, bottom), with `TRACKS` parallel tracks per side. Each outgoing track can be fed by the track of the same index on any one of the other three sides. Going across (left to right, top to bottom) is a straight connection. Going to a neighbouring side (for example left to top) is a turn. Every possible connection has its own stored enable bit.

The enable bits are loaded at programming time through a serial shift chain while `cfg_en` is high. After that they hold their values. In normal operation the path from `trk_in` to `trk_out` is purely combinational. No data handshake applies: tracks are static wires with no back-pressure. If several enables are set for one output, a fixed priority settles the choice, so a track is never driven by two sources at once.

Top module: `swbox_top`

## Requirements
- R1: While `rst_n` is low, every bit of `trk_out` is 0 and the stored enables are cleared.
- R2: While `cfg_en` is high, every bit of `trk_out` is 0 whatever `trk_in` carries.
- R3: Until 4*TRACKS*3 bits have been shifted in since reset, `trk_out` stays 0 even with `cfg_en` low.
- R4: Each cycle with `cfg_en` high shifts `cfg_din` into the chain from the top end. After a full load, the first bit shifted in sits at index 0 and the last at index 4*TRACKS*3-1. The enable for output side s (left=0, right=1, top=2, bottom=3), track t and source slot k is at index (s*TRACKS+t)*3+k.
- R5: The source slots of a side are the three other sides in ascending side number. Slot k names side k when k < s, and side k+1 otherwise.
- R6: When exactly one enable of an output is set, the output equals the same-index input track of the side that slot names. This covers both straight and turning connections.
- R7: When several enables of one output are set, the lowest-numbered slot alone decides the output.
- R8: An output with no enable set reads 0.
- R9: After a full load with `cfg_en` low, a change on `trk_in` shows on `trk_out` with no clock edge in between.
- R10: With `cfg_en` low, `cfg_din` has no effect on the stored enables or on the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration chain |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Shift enable for the configuration chain |
| cfg_din | input | 1 | Serial configuration data |
| trk_in | input | 4*TRACKS | Incoming tracks; bit side*TRACKS+track |
| trk_out | output | 4*TRACKS | Outgoing tracks; bit side*TRACKS+track |

## Verification
The hardest case to reach from the ports is a partly loaded chain. After reset, fewer than the full number of bits have gone in, yet `cfg_en` is low. The outputs must then stay dark even though some enables are already set. The stimulus shifts in a partial, mostly-ones pattern and then drops `cfg_en` while the inputs are random. Only after that does it complete a full load. Priority among several enables is reached with all-ones and random configurations. Single-bit configurations at both ends of the chain pin down the bit order.

// File: rtl/swbox_pkg.sv
`timescale 1ns/1ps
package swbox_pkg;
  localparam int NUM_SIDES = 4;
  localparam int NUM_SRC   = NUM_SIDES - 1;

  typedef enum logic [1:0] {
    SIDE_L = 2'd0,
    SIDE_R = 2'd1,
    SIDE_T = 2'd2,
    SIDE_B = 2'd3
  } side_e;

  // Source slot k of output side s names the k-th other side in ascending order.
  function automatic int src_side(input int s, input int k);
    return (k < s) ? k : k + 1;
  endfunction
endpackage

// File: rtl/swbox_cfg_chain.sv
`timescale 1ns/1ps
module swbox_cfg_chain #(
  parameter int CFG_BITS = 36
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                shift_en,
  input  logic                ser_in,
  output logic [CFG_BITS-1:0] cfg_q,
  output logic                full
);
  localparam int CW = $clog2(CFG_BITS + 1);

  logic [CW-1:0] shift_cnt;

  // New bits enter at the top end and move toward index 0.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (shift_en) begin
      cfg_q <= {ser_in, cfg_q[CFG_BITS-1:1]};
    end
  end

  // Saturating count of bits taken since reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_cnt <= '0;
    end else if (shift_en && (shift_cnt != CW'(CFG_BITS))) begin
      shift_cnt <= shift_cnt + 1'b1;
    end
  end

  assign full = (shift_cnt == CW'(CFG_BITS));
endmodule

// File: rtl/swbox_track_mux.sv
`timescale 1ns/1ps
module swbox_track_mux #(
  parameter int NSRC = 3
) (
  input  logic [NSRC-1:0] en,
  input  logic [NSRC-1:0] src,
  input  logic            gate,
  output logic            out
);
  logic pick;

  // Walk from the highest slot down so the lowest enabled slot wins.
  always_comb begin
    pick = 1'b0;
    for (int k = NSRC - 1; k >= 0; k--) begin
      if (en[k]) pick = src[k];
    end
  end

  assign out = pick & gate;
endmodule

// File: rtl/swbox_top.sv
`timescale 1ns/1ps
module swbox_top #(
  parameter int TRACKS = 3
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   cfg_en,
  input  logic                                   cfg_din,
  input  logic [swbox_pkg::NUM_SIDES*TRACKS-1:0] trk_in,
  output logic [swbox_pkg::NUM_SIDES*TRACKS-1:0] trk_out
);
  import swbox_pkg::*;

  localparam int NOUT     = NUM_SIDES * TRACKS;
  localparam int CFG_BITS = NOUT * NUM_SRC;

  logic [CFG_BITS-1:0] cfg_bits;
  logic                chain_full;
  logic                route_on;

  swbox_cfg_chain #(.CFG_BITS(CFG_BITS)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (cfg_en),
    .ser_in   (cfg_din),
    .cfg_q    (cfg_bits),
    .full     (chain_full)
  );

  assign route_on = chain_full & ~cfg_en;

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    for (genvar t = 0; t < TRACKS; t++) begin : g_trk
      localparam int OIDX = s * TRACKS + t;
      logic [NUM_SRC-1:0] srcs;
      for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
        localparam int SS = src_side(s, k);
        assign srcs[k] = trk_in[SS*TRACKS + t];
      end
      swbox_track_mux #(.NSRC(NUM_SRC)) u_mux (
        .en   (cfg_bits[OIDX*NUM_SRC +: NUM_SRC]),
        .src  (srcs),
        .gate (route_on),
        .out  (trk_out[OIDX])
      );
    end
  end
endmodule

// File: rtl/swbox_checker.sv
`timescale 1ns/1ps
module swbox_checker #(
  parameter int TRACKS = 3
) (
  input logic                                                    clk,
  input logic                                                    rst_n,
  input logic                                                    cfg_en,
  input logic [swbox_pkg::NUM_SIDES*TRACKS-1:0]                  trk_in,
  input logic [swbox_pkg::NUM_SIDES*TRACKS-1:0]                  trk_out,
  input logic [swbox_pkg::NUM_SIDES*TRACKS*swbox_pkg::NUM_SRC-1:0] cfg_q
);
  import swbox_pkg::*;

  localparam int NOUT     = NUM_SIDES * TRACKS;
  localparam int CFG_BITS = NOUT * NUM_SRC;
  localparam int CW       = $clog2(CFG_BITS + 1);

  logic [CW-1:0] seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= '0;
    else if (cfg_en && (seen != CW'(CFG_BITS))) seen <= seen + 1'b1;
  end

  p_reset_dark_r1: assert property (@(posedge clk) !rst_n |-> (trk_out == '0));

  p_cfg_dark_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |-> (trk_out == '0));

  p_partial_dark_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (seen != CW'(CFG_BITS)) |-> (trk_out == '0));

  p_hold_cfg_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en ##1 (!cfg_en && $stable(trk_in))) |-> $stable(trk_out));

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_cs
    for (genvar t = 0; t < TRACKS; t++) begin : g_ct
      localparam int OI = s * TRACKS + t;
      logic [NUM_SRC-1:0] hit;
      for (genvar k = 0; k < NUM_SRC; k++) begin : g_ck
        localparam int SS = src_side(s, k);
        assign hit[k] = cfg_q[OI*NUM_SRC + k] & trk_in[SS*TRACKS + t];
      end
      p_route_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        trk_out[OI] |-> (hit != '0));
      p_no_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[OI*NUM_SRC +: NUM_SRC] == '0) |-> !trk_out[OI]);
    end
  end
endmodule

bind swbox_top swbox_checker #(.TRACKS(TRACKS)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cfg_en  (cfg_en),
  .trk_in  (trk_in),
  .trk_out (trk_out),
  .cfg_q   (cfg_bits)
);

// File: tb/swbox_top_test.sv
`timescale 1ns/1ps
module swbox_top_test;
  localparam int PERIOD = 10;
  localparam int T      = 3;
  localparam int NOUT   = 4 * T;
  localparam int NCFG   = NOUT * 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cfg_en = 1'b0;
  logic            cfg_din = 1'b0;
  logic [NOUT-1:0] trk_in = '0;
  logic [NOUT-1:0] trk_out;

  int checks = 0;
  int fails  = 0;

  logic [NOUT-1:0] exp_q[$];
  string           req_q[$];

  logic [NCFG-1:0] model_cfg = '0;
  bit              model_loaded = 1'b0;

  swbox_top #(.TRACKS(T)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_din(cfg_din),
    .trk_in(trk_in), .trk_out(trk_out)
  );

  always #(PERIOD/2) clk = ~clk;

  // Reference: slot k of side s is side k if k<s else k+1; lowest enabled slot wins.
  function automatic logic [NOUT-1:0] ref_route(input logic [NCFG-1:0] c,
                                                input logic [NOUT-1:0] x);
    logic [NOUT-1:0] o = '0;
    for (int s = 0; s < 4; s++)
      for (int t = 0; t < T; t++)
        for (int k = 2; k >= 0; k--)
          if (c[(s*T+t)*3+k]) o[s*T+t] = x[((k < s) ? k : k+1)*T + t];
    return o;
  endfunction

  task automatic push(input logic [NOUT-1:0] e, input string r);
    exp_q.push_back(e);
    req_q.push_back(r);
  endtask

  task automatic shift_cfg(input logic [NCFG-1:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cfg_en  = 1'b1;
      cfg_din = v[i];
      trk_in  = NOUT'($urandom);
      push('0, "R2");
    end
    if (n >= NCFG) begin model_cfg = v; model_loaded = 1'b1; end
  endtask

  task automatic apply(input logic [NOUT-1:0] x, input string r);
    @(negedge clk);
    cfg_en  = 1'b0;
    cfg_din = 1'($urandom);
    trk_in  = x;
    push(model_loaded ? ref_route(model_cfg, x) : '0, r);
  endtask

  task automatic drain;
    wait (exp_q.size() == 0);
    @(posedge clk);
  endtask

  // Monitor: compare a quarter period after each edge.
  initial begin
    logic [NOUT-1:0] e;
    string r;
    forever begin
      @(posedge clk);
      #(PERIOD/4);
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        r = req_q.pop_front();
        checks++;
        if (trk_out !== e) begin
          fails++;
          $display("FAIL %s: trk_out=%h expected=%h", r, trk_out, e);
        end
      end
    end
  end

  initial begin
    #(PERIOD*100000);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [NCFG-1:0] c;
    logic [NOUT-1:0] x;
    // R1: reset holds outputs dark
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      trk_in = NOUT'($urandom) | 1;
      push('0, "R1");
    end
    @(negedge clk);
    rst_n = 1'b1;
    // R3: partial load of ones, then cfg_en low
    shift_cfg('1, 20);
    for (int i = 0; i < 4; i++) apply(NOUT'($urandom), "R3");
    apply('1, "R3");
    drain();
    // R6: straight-through (L<-R slot0, R<-L slot0, T<-B slot2, B<-T slot2)
    c = '0;
    for (int t = 0; t < T; t++) begin
      c[(0*T+t)*3+0] = 1'b1;
      c[(1*T+t)*3+0] = 1'b1;
      c[(2*T+t)*3+2] = 1'b1;
      c[(3*T+t)*3+2] = 1'b1;
    end
    shift_cfg(c, NCFG);
    for (int i = 0; i < 6; i++) apply(NOUT'($urandom), "R6");
    drain();
    // R4: only bit 0 -> left track0 from right track0; only last bit -> bottom track2 from top track2
    shift_cfg(NCFG'(1), NCFG);
    apply(NOUT'(1) << (1*T+0), "R4");
    apply(~(NOUT'(1) << (1*T+0)), "R4");
    shift_cfg(NCFG'(1) << (NCFG-1), NCFG);
    apply(NOUT'(1) << (2*T+2), "R4");
    drain();
    // R5: turning connections, slot 1 on every output
    c = '0;
    for (int o = 0; o < NOUT; o++) c[o*3+1] = 1'b1;
    shift_cfg(c, NCFG);
    for (int i = 0; i < 6; i++) apply(NOUT'($urandom), "R5");
    drain();
    // R7: all enables set, lowest slot wins
    shift_cfg('1, NCFG);
    for (int i = 0; i < 6; i++) apply(NOUT'($urandom), "R7");
    drain();
    // R9: combinational update without a clock edge
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      x = NOUT'($urandom);
      trk_in = x;
      #1;
      checks++;
      if (trk_out !== ref_route(model_cfg, x)) begin
        fails++;
        $display("FAIL R9: trk_out=%h expected=%h", trk_out, ref_route(model_cfg, x));
      end
    end
    // R8: no enables, outputs zero
    shift_cfg('0, NCFG);
    apply('1, "R8");
    for (int i = 0; i < 3; i++) apply(NOUT'($urandom), "R8");
    drain();
    // R10 with random configurations: cfg_din toggles while cfg_en low
    for (int r = 0; r < 12; r++) begin
      c = {$urandom, $urandom};
      shift_cfg(c, NCFG);
      for (int i = 0; i < 8; i++) apply(NOUT'($urandom), "R10");
    end
    drain();
    #(PERIOD);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule